// File: doc/BRIEF.md
# Flow-Gated Serial Transmitter

This block sends 8-bit characters on an asynchronous serial line. Each frame has one start bit, eight data bits sent least significant bit first, and one stop bit. The line idles high. Every bit lasts `CLKS_PER_BIT` clocks. Characters arrive through a valid/ready input that feeds a single-entry holding register. `in_ready` is high exactly while that register is empty. A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. While the register is full, `in_ready` stays low and the upstream source must keep its data waiting. The register empties on the edge where its contents move into the shifter, which is the same edge on which the start bit appears on `tx`.

The peer controls flow through the active-low `cts_n` input. This input passes through a two-flop synchronizer before anything looks at it. A character in flight always completes. Only the start of the following character is gated:

- **Idle transmitter:** a waiting character starts on the first clock in which the synchronized level is low.
- **Transmitter sending a stop bit:** the synchronized level is captured `CTS_LEAD` clocks before the stop bit ends. That one capture alone decides whether a waiting character follows back-to-back, with no idle clock between frames.

A sticky change flag records every transition of the synchronized flow-control level. It holds until it is cleared with a strobe.

Top module: `uart_cts_tx`

## Requirements
- R1: A frame is a start bit (0), eight data bits with bit 0 first, and a stop bit (1). Each bit drives `tx` for exactly `CLKS_PER_BIT` clocks. `tx` is 1 whenever no frame is in progress.
- R2: `in_ready` is 1 exactly when the holding register is empty. A transfer (`in_valid` and `in_ready` high at a clock edge) makes `in_ready` 0 from the next cycle on. `in_ready` returns to 1 on the edge where the start bit of that character begins.
- R3: When the transmitter is idle and the synchronized `cts_n` is 1, a stored character is not sent: `tx` stays 1, `busy` stays 0, and `in_ready` stays 0.
- R4: When `cts_n` goes low after an idle wait, the stored character's start bit appears on `tx` three clocks later: two synchronizer stages plus one load edge.
- R5: A frame already in progress always completes in full, whatever `cts_n` does during it.
- R6: `cts_n` is sampled `CTS_LEAD` clocks before the end of the stop bit. If that sample is 0 and a character is waiting, the next start bit begins on the very next clock after the stop bit, with no idle cycle.
- R7: If that sample is 1, the next character does not start at the end of the stop bit, even if `cts_n` has gone low since. The transmitter returns to idle for at least one clock, and then the idle rule of R3 and R4 applies.
- R8: `busy` is 1 from the first clock of the start bit to the last clock of the stop bit. It stays 1 across back-to-back frames and is 0 while idle.
- R9: `cts_chg` becomes 1 after each rising or falling transition of the synchronized `cts_n`. It stays 1 until `clr_chg` is pulsed. A clear that coincides with a new transition leaves it at 1.
- R10: After reset, `tx`=1, `busy`=0, `in_ready`=1 and `cts_chg`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Upstream has a character |
| in_ready | output | 1 | Holding register empty; transfer on valid and ready |
| in_data | input | 8 | Character to send |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| clr_chg | input | 1 | Strobe that clears the change flag |
| tx | output | 1 | Serial line, idle high |
| busy | output | 1 | A frame is on the line |
| cts_chg | output | 1 | Sticky flow-control change flag |

## Verification
The bench targets the stop-bit sampling window. It releases `cts_n` two clocks before the stop bit ends, after the sample point, and expects exactly one idle clock before the next start bit. A design that looked at the live level at the frame boundary would join the frames back-to-back instead. The bench also checks that the gap is zero when `cts_n` stays low; a design that always returned to idle would show an extra high clock between frames. Deasserting `cts_n` in mid-frame must not truncate the frame. A clear strobe that lands on the same edge as a new transition must leave the flag set; a design that gave the clear priority would lose that event.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/uart_cts_sync.sv
// Synchronizes the asynchronous flow-control input and keeps a sticky
// record of every transition of the synchronized level.
module uart_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic clr_chg,
  output logic cts_lvl,
  output logic cts_chg
);
  localparam int CW = STAGES + 1;

  logic [CW-1:0] chain;
  logic          toggled;

  // Deasserted (1) is the safe reset value for every stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[CW-2:0], cts_n};
  end

  assign cts_lvl = chain[STAGES-1];
  assign toggled = chain[STAGES-1] ^ chain[STAGES];

  // A new transition outranks a clear arriving on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_chg <= 1'b0;
    else        cts_chg <= toggled | (cts_chg & ~clr_chg);
  end
endmodule

// File: rtl/uart_cts_hold.sv
// Single-entry holding register with a valid/ready input side.
module uart_cts_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  assign in_ready = !full;
endmodule

// File: rtl/uart_cts_shift.sv
// Bit timer, frame shifter and start gating.
module uart_cts_shift
  import uart_cts_pkg::*;
#(
  parameter int W            = 8,
  parameter int CLKS_PER_BIT = 16,
  parameter int CTS_LEAD     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_full,
  input  logic [W-1:0] hold_data,
  input  logic         cts_lvl,
  output logic         take,
  output logic         tx,
  output logic         busy
);
  localparam int NBITS = W + 2;
  localparam int CW    = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BW    = $clog2(NBITS);
  localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] CNT_SAMP = CW'(CLKS_PER_BIT - CTS_LEAD);
  localparam logic [BW-1:0] BIT_STOP = BW'(NBITS - 1);

  tx_state_e     state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [W:0]    rest;     // remaining data bits plus the stop bit
  logic          cts_ok;   // start permission captured near the end of the stop bit
  logic          bit_end;
  logic          frame_end;
  logic          start_idle;
  logic          start_b2b;

  assign bit_end    = (state == TX_SEND) && (cnt == CNT_LAST);
  assign frame_end  = bit_end && (bidx == BIT_STOP);
  assign start_idle = (state == TX_IDLE) && hold_full && !cts_lvl;
  assign start_b2b  = frame_end && hold_full && cts_ok;
  assign take       = start_idle || start_b2b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      rest  <= '1;
      tx    <= 1'b1;
    end else if (take) begin
      state <= TX_SEND;
      cnt   <= '0;
      bidx  <= '0;
      rest  <= {1'b1, hold_data};
      tx    <= 1'b0;
    end else if (frame_end) begin
      state <= TX_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      tx    <= 1'b1;
    end else if (bit_end) begin
      cnt   <= '0;
      bidx  <= bidx + 1'b1;
      tx    <= rest[0];
      rest  <= {1'b1, rest[W:1]};
    end else if (state == TX_SEND) begin
      cnt   <= cnt + 1'b1;
    end
  end

  // One capture per frame, CTS_LEAD clocks before the stop bit ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_ok <= 1'b0;
    else if ((state == TX_SEND) && (bidx == BIT_STOP) && (cnt == CNT_SAMP))
      cts_ok <= !cts_lvl;
  end

  assign busy = (state == TX_SEND);
endmodule

// File: rtl/uart_cts_tx.sv
// Top level: flow-gated serial transmitter. CLKS_PER_BIT must exceed CTS_LEAD.
module uart_cts_tx #(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 16,
  parameter int CTS_LEAD     = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cts_n,
  input  logic              clr_chg,
  output logic              tx,
  output logic              busy,
  output logic              cts_chg
);
  logic              cts_lvl;
  logic              take;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;

  uart_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .cts_n   (cts_n),
    .clr_chg (clr_chg),
    .cts_lvl (cts_lvl),
    .cts_chg (cts_chg)
  );

  uart_cts_hold #(.W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .take     (take),
    .full     (hold_full),
    .data     (hold_data)
  );

  uart_cts_shift #(
    .W            (DATA_W),
    .CLKS_PER_BIT (CLKS_PER_BIT),
    .CTS_LEAD     (CTS_LEAD)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .cts_lvl   (cts_lvl),
    .take      (take),
    .tx        (tx),
    .busy      (busy)
  );
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic tx,
  input logic busy,
  input logic cts_chg,
  input logic clr_chg,
  input logic cts_lvl
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx); // R1

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx); // R1

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_IDLE_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cts_lvl)); // R3

  AST_CHG_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_lvl != $past(cts_lvl)) |=> cts_chg); // R9

  AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_chg && !clr_chg) |=> cts_chg); // R9
endmodule

bind uart_cts_tx uart_cts_tx_chk u_chk (.*);

// File: tb/uart_cts_tx_tb.sv
`timescale 1ns/1ps
module uart_cts_tx_tb;
  localparam int CPB = 8;
  localparam int NB  = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       cts_n = 1'b0;
  logic       clr_chg = 1'b0;
  logic       in_ready, tx, busy, cts_chg;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  uart_cts_tx #(.DATA_W(8), .CLKS_PER_BIT(CPB), .CTS_LEAD(3), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cts_n(cts_n), .clr_chg(clr_chg),
    .tx(tx), .busy(busy), .cts_chg(cts_chg)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Caller stands at a negedge; returns at the negedge after acceptance.
  task automatic send(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Checks a whole frame cycle by cycle; returns at the first negedge after it.
  task automatic check_frame(input logic [7:0] b, input bit now, input string req);
    int bad = 0;
    if (!now) while (tx !== 1'b0) @(negedge clk);
    for (int i = 0; i < NB; i++) begin
      logic e;
      e = (i == 0) ? 1'b0 : (i == NB - 1) ? 1'b1 : b[i-1];
      for (int c = 0; c < CPB; c++) begin
        if (tx !== e || busy !== 1'b1) bad++;
        @(negedge clk);
      end
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic clear_flag();
    clr_chg = 1'b1;
    @(negedge clk);
    clr_chg = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(tx === 1'b1 && busy === 1'b0 && in_ready === 1'b1 && cts_chg === 1'b0,
          "R10 reset outputs", {tx, busy, in_ready, cts_chg}, 4'b1010);
  endtask

  task automatic t_single();
    send(8'hA5);
    check(in_ready === 1'b0, "R2 ready low after accept", in_ready, 0);
    check_frame(8'hA5, 1'b0, "R1 frame A5 bits and timing");
    check(busy === 1'b0 && tx === 1'b1, "R8 busy low after stop", {busy, tx}, 2'b01);
    send(8'h6E);
    check_frame(8'h6E, 1'b0, "R1 frame 6E bits and timing");
  endtask

  task automatic t_cts_hold();
    int bad = 0;
    int n = 0;
    cts_n = 1'b1;
    repeat (4) @(negedge clk);
    send(8'h3C);
    for (int i = 0; i < 40; i++) begin
      if (tx !== 1'b1 || busy !== 1'b0 || in_ready !== 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R3 held while cts high", bad, 0);
    cts_n = 1'b0;
    while (tx !== 1'b0 && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n == 3, "R4 start latency after cts low", n, 3);
    check(in_ready === 1'b1, "R2 ready on start edge", in_ready, 1);
    check_frame(8'h3C, 1'b1, "R1 held frame 3C");
  endtask

  task automatic t_mid_frame();
    send(8'h81);
    fork
      check_frame(8'h81, 1'b0, "R5 frame completes after cts high");
      begin
        while (tx !== 1'b0) @(negedge clk);
        repeat (20) @(negedge clk);
        cts_n = 1'b1;
      end
    join
    check(tx === 1'b1 && busy === 1'b0, "R5 idle after frame", {tx, busy}, 2'b01);
    cts_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_b2b();
    send(8'h12);
    fork
      send(8'hF0);
      check_frame(8'h12, 1'b0, "R6 first of pair");
    join
    check(tx === 1'b0 && busy === 1'b1, "R6 no gap between frames", {tx, busy}, 2'b01);
    check_frame(8'hF0, 1'b1, "R8 second frame busy held");
  endtask

  task automatic t_late_cts();
    send(8'h55);
    while (tx !== 1'b0) @(negedge clk);
    send(8'hC3);
    cts_n = 1'b1;
    repeat (NB * CPB - 3) @(negedge clk);
    cts_n = 1'b0;
    repeat (2) @(negedge clk);
    check(tx === 1'b1 && busy === 1'b0 && in_ready === 1'b0,
          "R7 idle cycle after late cts", {tx, busy, in_ready}, 3'b100);
    @(negedge clk);
    check(tx === 1'b0, "R7 start after idle cycle", tx, 0);
    check_frame(8'hC3, 1'b1, "R7 late frame C3");
  endtask

  task automatic t_flag();
    clear_flag();
    check(cts_chg === 1'b0, "R9 flag cleared", cts_chg, 0);
    cts_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cts_chg === 1'b1, "R9 set on rising", cts_chg, 1);
    repeat (10) @(negedge clk);
    check(cts_chg === 1'b1, "R9 sticky", cts_chg, 1);
    clear_flag();
    check(cts_chg === 1'b0, "R9 clear strobe", cts_chg, 0);
    cts_n = 1'b0;
    repeat (4) @(negedge clk);
    check(cts_chg === 1'b1, "R9 set on falling", cts_chg, 1);
    clear_flag();
    cts_n = 1'b1;
    repeat (2) @(negedge clk);
    clr_chg = 1'b1;
    @(negedge clk);
    clr_chg = 1'b0;
    check(cts_chg === 1'b1, "R9 edge beats clear", cts_chg, 1);
    cts_n = 1'b0;
    repeat (4) @(negedge clk);
    clear_flag();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_single();
    t_cts_hold();
    t_mid_frame();
    t_b2b();
    t_late_cts();
    t_flag();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule